// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps seconds, minutes and hours and advances them by one second on each cycle where the update strobe is high. Values are held as bytes in either plain binary or packed BCD. Hours are kept in either 24-hour or 12-hour form. In 12-hour form, bit 7 of the hours byte marks PM. Two copies of the time exist. The internal copy advances on every strobe. The host reads and writes the user copy through a small synchronous register port, and that copy takes each new time unless a freeze bit is set.

On every strobe, the newly advanced internal time is compared with three alarm bytes. An alarm byte whose two top bits are both 1 matches any value of its field. When all three fields match, a one-cycle alarm pulse is produced. An update-done pulse follows each transfer into the user copy. An optional daylight-saving rule moves 1:59:59 AM forward to 3:00:00 on a spring-forward day. On a fall-back day it moves 1:59:59 AM back to 1:00:00, once only. The calendar logic supplies these two day indications as inputs.

Top module: `tod_alarm_clock`

## Requirements
- R1: After reset, every time and alarm byte reads 0x00 and the control byte reads 0x02. Register map: 0 seconds, 1 minutes, 2 hours, 3 seconds alarm, 4 minutes alarm, 5 hours alarm, 6 control. Control bits: bit0 freeze, bit1 24-hour (1 = 24-hour), bit2 binary (1 = binary, 0 = BCD), bit3 daylight-saving enable. Reads are combinational from `addr_i`.
- R2: In BCD 24-hour mode, each strobe advances the time by one second. Seconds and minutes roll over from 59 to 00, and 23:59:59 becomes 00:00:00. Each byte is packed BCD: tens in bits 7:4, units in bits 3:0.
- R3: In binary mode, the same counting applies, and each byte holds the plain binary value.
- R4: In 12-hour mode, the hour count runs 12, 1, ..., 11, with the hour in bits 6:0 (BCD or binary). Bit 7 (PM) toggles on the 11:59:59 to 12:00:00 transition.
- R5: While freeze is 1, a strobe leaves the user copy unchanged, and host writes to bytes 0 to 2 land in the user copy. The internal copy keeps advancing, and alarms are still matched against it. Clearing freeze loads the internal copy from the user copy.
- R6: While freeze is 0, host writes to bytes 0 to 2 are ignored.
- R7: Bit 7 of the seconds byte is read-only and reads 0.
- R8: The cycle after a strobe, `alarm_o` is high for one cycle if the advanced time equals all three alarm bytes.
- R9: An alarm byte with bits 7:6 = 11 matches any value. A don't-care in the hours alarm alone gives one alarm per hour. Don't-care in all three gives an alarm on every strobe.
- R10: `upd_done_o` is high for one cycle after each strobe taken while freeze is 0. It stays low for strobes taken while freeze is 1.
- R11: With daylight saving enabled and `spring_fwd_i` high, 1:59:59 AM advances to 3:00:00 AM. 1:59:59 PM in 12-hour mode is not adjusted.
- R12: With daylight saving enabled and `fall_back_i` high, the first arrival at 1:59:59 AM goes to 1:00:00 AM. The second arrival, while `fall_back_i` stays high, goes on to 2:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second update strobe |
| spring_fwd_i | input | 1 | Today is the spring-forward day |
| fall_back_i | input | 1 | Today is the fall-back day |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| alarm_o | output | 1 | Alarm match pulse |
| upd_done_o | output | 1 | User copy updated pulse |

## Verification
The hardest state to reach is the one-shot fall-back rule. Showing that the repeat is suppressed needs a full hour of strobes after the first adjustment, so that 1:59:59 AM comes round a second time with `fall_back_i` still high. The stimulus seeds the time just below that instant and then issues 3603 strobes, checking every second against an arithmetic seconds-of-day model. The frozen-copy alarm case is also indirect, since the internal copy is not readable. It is reached by freezing at a known time and counting strobes until an alarm set a few seconds ahead fires, while the user bytes stay put.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int ADDR_W   = 3;
  localparam int BYTE_W   = 8;
  localparam int N_FIELDS = 3;   // 0 sec, 1 min, 2 hour
  localparam int NUM_W    = 7;

  localparam logic [ADDR_W-1:0] A_ALM0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd6;

  localparam int CB_SET = 0;
  localparam int CB_H24 = 1;
  localparam int CB_BIN = 2;
  localparam int CB_DSE = 3;

  localparam logic [NUM_W-1:0] SEC_LAST = 7'd59;
  localparam logic [NUM_W-1:0] H24_LAST = 7'd23;

  typedef logic [N_FIELDS-1:0][BYTE_W-1:0] tod_t;

  function automatic logic [NUM_W-1:0] to_num(input logic [BYTE_W-1:0] b, input logic bin);
    logic [NUM_W-1:0] r;
    r = 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    return bin ? b[6:0] : r;
  endfunction

  function automatic logic [BYTE_W-1:0] to_byte(input logic [NUM_W-1:0] n, input logic bin);
    logic [NUM_W-1:0] tens, ones;
    tens = n / 7'd10;
    ones = n - tens * 7'd10;
    return bin ? {1'b0, n} : {tens[3:0], ones[3:0]};
  endfunction
endpackage

// File: rtl/tod_advance.sv
`timescale 1ns/1ps
module tod_advance
  import tod_pkg::*;
(
  input  tod_t t_i,
  input  logic bin_i,
  input  logic h24_i,
  input  logic dse_i,
  input  logic spring_i,
  input  logic fall_i,
  input  logic fall_armed_i,
  output tod_t nxt_o,
  output logic fall_used_o
);
  logic [NUM_W-1:0] s, m, h, ns, nm, nh;
  logic pm, npm, at_edge;
  logic [BYTE_W-1:0] hb;

  always_comb begin
    s  = to_num(t_i[0], bin_i);
    m  = to_num(t_i[1], bin_i);
    h  = to_num({1'b0, t_i[2][6:0]}, bin_i);
    pm = ~h24_i & t_i[2][7];
    at_edge = (s == SEC_LAST) && (m == SEC_LAST) && (h == 7'd1) && !pm;
    ns = s; nm = m; nh = h; npm = pm;
    fall_used_o = 1'b0;
    if (dse_i && at_edge && spring_i) begin
      ns = '0; nm = '0; nh = 7'd3;
    end else if (dse_i && at_edge && fall_i && fall_armed_i) begin
      ns = '0; nm = '0; nh = 7'd1;
      fall_used_o = 1'b1;
    end else if (s != SEC_LAST) begin
      ns = s + 7'd1;
    end else begin
      ns = '0;
      if (m != SEC_LAST) begin
        nm = m + 7'd1;
      end else begin
        nm = '0;
        if (h24_i)             nh = (h == H24_LAST) ? '0 : h + 7'd1;
        else if (h == 7'd11) begin nh = 7'd12; npm = ~pm; end
        else if (h == 7'd12)   nh = 7'd1;
        else                   nh = h + 7'd1;
      end
    end
    hb       = to_byte(nh, bin_i);
    nxt_o[0] = to_byte(ns, bin_i);
    nxt_o[1] = to_byte(nm, bin_i);
    nxt_o[2] = {npm & ~h24_i, hb[6:0]};
  end
endmodule

// File: rtl/tod_alarm_cmp.sv
`timescale 1ns/1ps
module tod_alarm_cmp
  import tod_pkg::*;
(
  input  tod_t t_i,
  input  tod_t alm_i,
  output logic match_o
);
  logic [N_FIELDS-1:0] hit;
  for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
    assign hit[f] = (alm_i[f][7:6] == 2'b11) || (alm_i[f] == t_i[f]);
  end
  assign match_o = &hit;
endmodule

// File: rtl/tod_alarm_clock.sv
`timescale 1ns/1ps
module tod_alarm_clock
  import tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              spring_fwd_i,
  input  logic              fall_back_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              alarm_o,
  output logic              upd_done_o
);
  tod_t user_q, int_q, alm_q, nxt;
  logic set_q, h24_q, bin_q, dse_q, fall_done_q;
  logic alarm_q, upd_q, match, fall_used;
  logic ctrl_wr, release_set, user_load;

  assign ctrl_wr     = wr_en_i && (addr_i == A_CTRL);
  assign release_set = ctrl_wr && set_q && !wdata_i[CB_SET];
  assign user_load   = tick_i && !set_q;

  tod_advance u_adv (
    .t_i(int_q), .bin_i(bin_q), .h24_i(h24_q), .dse_i(dse_q),
    .spring_i(spring_fwd_i), .fall_i(fall_back_i), .fall_armed_i(!fall_done_q),
    .nxt_o(nxt), .fall_used_o(fall_used)
  );

  tod_alarm_cmp u_cmp (.t_i(nxt), .alm_i(alm_q), .match_o(match));

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
    localparam logic [BYTE_W-1:0] WMASK = (f == 0) ? 8'h7F : 8'hFF;
    logic time_wr, alm_wr;
    assign time_wr = wr_en_i && set_q && (addr_i == ADDR_W'(f));
    assign alm_wr  = wr_en_i && (addr_i == A_ALM0 + ADDR_W'(f));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        user_q[f] <= '0;
        int_q[f]  <= '0;
        alm_q[f]  <= '0;
      end else begin
        if (time_wr)        user_q[f] <= wdata_i & WMASK;
        else if (user_load) user_q[f] <= nxt[f];
        // release wins over a coincident strobe
        if (release_set)    int_q[f]  <= user_q[f];
        else if (tick_i)    int_q[f]  <= nxt[f];
        if (alm_wr)         alm_q[f]  <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q       <= 1'b0;
      h24_q       <= 1'b1;
      bin_q       <= 1'b0;
      dse_q       <= 1'b0;
      fall_done_q <= 1'b0;
      alarm_q     <= 1'b0;
      upd_q       <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        set_q <= wdata_i[CB_SET];
        h24_q <= wdata_i[CB_H24];
        bin_q <= wdata_i[CB_BIN];
        dse_q <= wdata_i[CB_DSE];
      end
      fall_done_q <= fall_back_i &&
                     (fall_done_q || (tick_i && fall_used && !release_set));
      alarm_q <= tick_i && match;
      upd_q   <= user_load;
    end
  end

  always_comb begin
    case (addr_i)
      3'd0, 3'd1, 3'd2: rdata_o = user_q[addr_i[1:0]];
      3'd3, 3'd4, 3'd5: rdata_o = alm_q[addr_i[1:0] - 2'd3];
      A_CTRL:           rdata_o = {4'b0, dse_q, bin_q, h24_q, set_q};
      default:          rdata_o = '0;
    endcase
  end

  assign alarm_o    = alarm_q;
  assign upd_done_o = upd_q;
endmodule

// File: rtl/tod_alarm_clock_chk.sv
`timescale 1ns/1ps
module tod_alarm_clock_chk
  import tod_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              set_q_i,
  input tod_t              user_q_i,
  input logic              alarm_o,
  input logic              upd_done_o
);
  // R5: frozen user copy holds without a host write
  a_r5_frozen_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_q_i && !wr_en_i) |=> $stable(user_q_i));

  // R6: time writes with freeze clear have no effect
  a_r6_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_q_i && wr_en_i && (addr_i < 3'd3) && !tick_i) |=> $stable(user_q_i));

  // R7: seconds MSB stays clear
  a_r7_sec_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_q_i[0][7]);

  // R8: alarm only right after a strobe
  a_r8_alarm_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> $past(tick_i));

  // R10: update pulse follows an unfrozen strobe, and only then
  a_r10_upd_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !set_q_i) |=> upd_done_o);
  a_r10_upd_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |-> ($past(tick_i) && !$past(set_q_i)));
endmodule

bind tod_alarm_clock tod_alarm_clock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .set_q_i(set_q), .user_q_i(user_q),
  .alarm_o(alarm_o), .upd_done_o(upd_done_o)
);

// File: tb/tod_alarm_clock_tb.sv
`timescale 1ns/1ps
module tod_alarm_clock_tb_top;
  localparam real CLK_HALF = 2.5;
  localparam int  DAY = 86400;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, spring = 1'b0, fall = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic alarm, upd;

  int checks = 0, failures = 0;
  bit finished = 0;
  int cur = 0;
  bit fb = 0;
  bit c_bin = 0, c_h24 = 1, c_dse = 0;
  logic [7:0] alm_b [3];

  always #(CLK_HALF) clk = ~clk;

  tod_alarm_clock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .spring_fwd_i(spring),
    .fall_back_i(fall), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .alarm_o(alarm), .upd_done_o(upd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int n, input bit bin);
    return bin ? 8'(n) : 8'(((n / 10) << 4) | (n % 10));
  endfunction

  // returns {hour, min, sec}
  function automatic logic [23:0] fmt(input int t, input bit bin, input bit h24);
    int h, m, s, h12;
    logic [7:0] hb;
    h = t / 3600; m = (t / 60) % 60; s = t % 60;
    if (h24) hb = enc(h, bin);
    else begin
      h12 = (h % 12 == 0) ? 12 : h % 12;
      hb = enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
    end
    return {hb, enc(m, bin), enc(s, bin)};
  endfunction

  function automatic logic [7:0] ctl(input bit setb);
    return {4'b0, c_dse, c_bin, c_h24, setb};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_time(output logic [23:0] t);
    logic [7:0] b0, b1, b2;
    rd(3'd0, b0); rd(3'd1, b1); rd(3'd2, b2);
    t = {b2, b1, b0};
  endtask

  task automatic do_tick(output logic a, output logic u);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    a = alarm; u = upd;
  endtask

  task automatic model_step();
    if (!fall) fb = 0;
    if (c_dse && cur == 7199 && spring) cur = 10800;
    else if (c_dse && cur == 7199 && fall && !fb) begin cur = 3600; fb = 1; end
    else cur = (cur + 1) % DAY;
  endtask

  function automatic bit exp_alarm(input logic [23:0] e);
    bit ok;
    ok = 1;
    for (int f = 0; f < 3; f++)
      if (!(alm_b[f][7:6] == 2'b11 || alm_b[f] == e[8*f +: 8])) ok = 0;
    return ok;
  endfunction

  task automatic set_alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    alm_b[0] = s; alm_b[1] = m; alm_b[2] = h;
    wr(3'd3, s); wr(3'd4, m); wr(3'd5, h);
  endtask

  task automatic set_time(input int t);
    logic [23:0] e;
    e = fmt(t, c_bin, c_h24);
    wr(3'd6, ctl(1));
    wr(3'd0, e[7:0]); wr(3'd1, e[15:8]); wr(3'd2, e[23:16]);
    wr(3'd6, ctl(0));
    cur = t;
  endtask

  task automatic step(input string treq, input string areq);
    logic a, u;
    logic [23:0] e, got;
    do_tick(a, u);
    model_step();
    e = fmt(cur, c_bin, c_h24);
    rd_time(got);
    chk(got == e, treq, 32'(got), 32'(e));
    chk(u == 1'b1, "R10 update pulse", 32'(u), 32'd1);
    chk(a == exp_alarm(e), areq, 32'(a), 32'(exp_alarm(e)));
  endtask

  task automatic run(input int n, input string treq, input string areq);
    for (int i = 0; i < n; i++) step(treq, areq);
  endtask

  initial begin
    #(CLK_HALF * 2 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [23:0] got, e;
    logic a, u;
    alm_b[0] = 0; alm_b[1] = 0; alm_b[2] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d);
      chk(d == 8'h00, "R1 reset byte", 32'(d), 32'h0);
    end
    rd(3'd6, d);
    chk(d == 8'h02, "R1 reset control", 32'(d), 32'h02);
    chk(alarm == 1'b0 && upd == 1'b0, "R1 reset pulses", 32'({alarm, upd}), 32'h0);

    // R6: write ignored when not frozen
    wr(3'd0, 8'h45);
    rd(3'd0, d);
    chk(d == 8'h00, "R6 ignored write", 32'(d), 32'h0);
    // R7: seconds MSB read-only
    wr(3'd6, ctl(1));
    wr(3'd0, 8'hB5);
    rd(3'd0, d);
    chk(d == 8'h35, "R7 seconds bit7", 32'(d), 32'h35);
    wr(3'd6, ctl(0));

    // R2 + R9: BCD 24h, hour-wise alarm at mm=00 ss=30
    set_alarm(8'h30, 8'h00, 8'hC0);
    set_time(0);
    run(3700, "R2 BCD count", "R9 hourly don't-care");
    set_time(23 * 3600 + 59 * 60 + 30);
    run(60, "R2 day wrap", "R9 hourly don't-care");

    // R3 + R9: binary, every-second alarm
    c_bin = 1;
    set_alarm(8'hFF, 8'hC1, 8'hE7);
    set_time(11 * 3600 + 59 * 60 + 30);
    run(60, "R3 binary count", "R9 all don't-care");

    // R4 + R8: 12-hour, exact alarm at 12:00:05 PM (BCD 0x92 0x00 0x05)
    c_bin = 0; c_h24 = 0;
    set_alarm(8'h05, 8'h00, 8'h92);
    set_time(43170);
    run(60, "R4 noon PM toggle", "R8 exact alarm");
    set_time(46790);
    run(20, "R4 12 to 1 PM", "R8 exact alarm");
    set_time(86390);
    run(20, "R4 midnight 12 AM", "R8 exact alarm");
    c_bin = 1;
    set_alarm(8'h05, 8'h00, 8'h8C);
    set_time(43190);
    run(20, "R4 binary 12h", "R8 exact alarm binary");

    // R5: freeze, internal keeps advancing and alarms on it
    c_bin = 0; c_h24 = 1;
    set_alarm(8'h03, 8'h00, 8'h10);
    set_time(36000);
    wr(3'd6, ctl(1));
    for (int k = 1; k <= 3; k++) begin
      do_tick(a, u);
      rd_time(got);
      e = fmt(36000, 0, 1);
      chk(got == e, "R5 frozen user copy", 32'(got), 32'(e));
      chk(u == 1'b0, "R10 no pulse while frozen", 32'(u), 32'd0);
      chk(a == (k == 3), "R5 alarm from internal copy", 32'(a), 32'(k == 3));
    end
    wr(3'd2, 8'h05); wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    rd_time(got);
    chk(got == 24'h050000, "R5 write while frozen", 32'(got), 32'h050000);
    wr(3'd6, ctl(0));
    cur = 5 * 3600;
    step("R5 load on release", "R8 no alarm");

    // R11: spring forward
    c_dse = 1; spring = 1'b1;
    set_alarm(8'h00, 8'h00, 8'h00);
    set_time(7198);
    run(2, "R11 spring forward", "R8 alarm");
    rd(3'd2, d);
    chk(d == 8'h03, "R11 hour after jump", 32'(d), 32'h03);
    c_h24 = 0;
    set_time(50398);
    run(2, "R11 PM untouched", "R8 alarm");
    rd(3'd2, d);
    chk(d == 8'h82, "R11 2 PM", 32'(d), 32'h82);
    spring = 1'b0;

    // R12: fall back once, then pass through on the repeat
    c_h24 = 1; fall = 1'b1; fb = 0;
    set_time(7198);
    run(3603, "R12 fall back once", "R8 alarm");
    chk(cur == 7201, "R12 model reached 2:00:01", 32'(cur), 32'd7201);
    fall = 1'b0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule